// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects interrupt requests from four sources for a small 8-bit processor core: an asynchronous external pin, a periodic time base tick, a real-time clock tick, and an overflow from either of two timers. Each source has an enable bit and a request flag. A global enable gates every source. Enables and flags live in two byte-wide control registers that the CPU reads and writes over a simple select/write bus. Software may also set or clear flags directly.

Pending requests are evaluated only on a strobe that marks the instruction phase boundary. A request that arrives between two strobes is therefore taken at the next one. An acknowledge needs the global enable, the source enable and the source flag, with the stack-full input low. When one is taken, the block pulses a push request for the program counter and presents the vector address of the winning source. In the same edge it clears the serviced flag and the global enable, so nesting is blocked unless software turns the global enable back on. A return-from-interrupt strobe sets the global enable again; a plain return strobe does not.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Control register 0 (select 0) holds global enable at bit 0, external/time base/RTC enables at bits 1/2/3, and external/time base/RTC flags at bits 4/5/6. A write stores these bits, and bit 7 always reads 0.
- R2: Control register 1 (select 1) holds the timer enable at bit 0 and the timer flag at bit 4. All other bits ignore writes and read 0.
- R3: A high-to-low transition on `int_n` sets the external flag two clock edges after it is sampled by the two-flop synchronizer. The flag reads 1 at the third edge after the pin changes. A low-to-high transition sets nothing.
- R4: A one-cycle pulse on `tb_tick`, `rtc_tick`, `tmr_ovf[0]` or `tmr_ovf[1]` sets the time base, RTC, timer or timer flag at the next edge.
- R5: An acknowledge occurs only at an edge where `t2_edge` is high, the global enable is 1, the stack is not full, and some source has both its enable and flag set. The cycle after that edge, `irq_push` is high for exactly one cycle and `irq_vector` reads 0x04 (external), 0x08 (time base), 0x0C (RTC) or 0x10 (timer).
- R6: The acknowledge clears the serviced flag and the global enable. All other flags and enables keep their values.
- R7: When several sources are pending at once, the external source wins, then the time base, then the RTC, then the timer.
- R8: While `stack_full` is high, no acknowledge occurs. The request stays pending and is taken at a later strobe once `stack_full` is low.
- R9: A `reti_exec` pulse sets the global enable. A `ret_exec` pulse leaves it unchanged.
- R10: Flags keep recording requests while the global enable is 0. Setting the global enable later lets them be acknowledged.
- R11: When a hardware request and a software write that clears the same flag occur in the same cycle, the flag ends up set.
- R12: Reset clears both registers and drives `irq_push` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_n | input | 1 | External request pin, asynchronous, falling edge active |
| tb_tick | input | 1 | Time base request pulse |
| rtc_tick | input | 1 | Real-time clock request pulse |
| tmr_ovf | input | NUM_TMR | Timer overflow pulses, any of them requests |
| t2_edge | input | 1 | Evaluation strobe at the phase boundary |
| stack_full | input | 1 | Return stack has no free entry |
| ret_exec | input | 1 | Plain return executed |
| reti_exec | input | 1 | Return from interrupt executed |
| bus_sel | input | 1 | Register select: 0 = control 0, 1 = control 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq_push | output | 1 | One-cycle program counter push request |
| irq_vector | output | VEC_W | Vector address of the last acknowledged source |

## Verification
Some properties are checked on every cycle. An acknowledge happens only on a strobe with the global enable set and never while the stack is full. Every push follows an acknowledge by one cycle and carries one of the four legal vectors. The global enable is low whenever a push is presented. Pushes never come in back-to-back cycles. RETI sets the global enable, and RET leaves it unchanged. Other behaviours need the bench's scenarios to show them: the exact register bit layouts, the synchronizer latency of the pin edge, the priority order among simultaneous requests, the hardware-set-over-software-clear rule, and a request held through a full stack and then serviced later.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int REG_W   = 8;
   localparam int NUM_SRC = 4;
   localparam int SRC_W   = $clog2(NUM_SRC);

   // source index equals priority rank (0 highest)
   typedef enum logic [SRC_W-1:0] {
      SRC_EXT = 2'd0,
      SRC_TB  = 2'd1,
      SRC_RTC = 2'd2,
      SRC_TMR = 2'd3
   } irq_src_e;

   // control register 0 bit positions
   localparam int C0_GIE    = 0;
   localparam int C0_EN_LO  = 1;
   localparam int C0_FL_LO  = 4;
   localparam int C0_NSRC   = 3;
   // control register 1 bit positions
   localparam int C1_EN_TMR = 0;
   localparam int C1_FL_TMR = 4;
endpackage

// File: rtl/irqv_sync_edge.sv
module irqv_sync_edge #(
   parameter int STAGES  = 2,
   parameter bit FALLING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic edge_pulse
);
   localparam logic IDLE = FALLING ? 1'b1 : 1'b0;

   // chain[0..STAGES-1] synchronizer, chain[STAGES] previous settled value
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){IDLE}};
      else        chain <= {chain[STAGES-1:0], pin};
   end

   generate
      if (FALLING) begin : g_fall
         assign edge_pulse = chain[STAGES] & ~chain[STAGES-1];
      end else begin : g_rise
         assign edge_pulse = ~chain[STAGES] & chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/irqv_regs.sv
module irqv_regs
   import irqv_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_sel,
   input  logic [REG_W-1:0]    wr_data,
   input  logic [NUM_SRC-1:0]  hw_set,
   input  logic                ack,
   input  logic [SRC_W-1:0]    ack_src,
   input  logic                reti,
   output logic                gie,
   output logic [NUM_SRC-1:0]  en,
   output logic [NUM_SRC-1:0]  flag,
   output logic [REG_W-1:0]    img0,
   output logic [REG_W-1:0]    img1
);
   logic               gie_n;
   logic [NUM_SRC-1:0] en_n, flag_n;

   always_comb begin
      gie_n  = gie;
      en_n   = en;
      flag_n = flag;
      if (wr_en && !wr_sel) begin
         gie_n                 = wr_data[C0_GIE];
         en_n[C0_NSRC-1:0]     = wr_data[C0_EN_LO +: C0_NSRC];
         flag_n[C0_NSRC-1:0]   = wr_data[C0_FL_LO +: C0_NSRC];
      end
      if (wr_en && wr_sel) begin
         en_n[SRC_TMR]   = wr_data[C1_EN_TMR];
         flag_n[SRC_TMR] = wr_data[C1_FL_TMR];
      end
      if (reti) gie_n = 1'b1;
      if (ack) begin
         gie_n           = 1'b0;
         flag_n[ack_src] = 1'b0;
      end
      flag_n = flag_n | hw_set;   // hardware request wins
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie  <= 1'b0;
         en   <= '0;
         flag <= '0;
      end else begin
         gie  <= gie_n;
         en   <= en_n;
         flag <= flag_n;
      end
   end

   always_comb begin
      img0 = '0;
      img0[C0_GIE]              = gie;
      img0[C0_EN_LO +: C0_NSRC] = en[C0_NSRC-1:0];
      img0[C0_FL_LO +: C0_NSRC] = flag[C0_NSRC-1:0];
      img1 = '0;
      img1[C1_EN_TMR] = en[SRC_TMR];
      img1[C1_FL_TMR] = flag[SRC_TMR];
   end
endmodule

// File: rtl/irqv_arb.sv
module irqv_arb
   import irqv_pkg::*;
(
   input  logic               strobe,
   input  logic               gie,
   input  logic               stack_full,
   input  logic [NUM_SRC-1:0] en,
   input  logic [NUM_SRC-1:0] flag,
   output logic               ack,
   output logic [SRC_W-1:0]   ack_src
);
   logic [NUM_SRC-1:0] pend;
   logic               any;

   assign pend = en & flag;

   // lowest index wins
   always_comb begin
      ack_src = '0;
      any     = 1'b0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend[i]) begin
            ack_src = SRC_W'(i);
            any     = 1'b1;
         end
      end
   end

   assign ack = strobe & gie & ~stack_full & any;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqv_pkg::*;
#(
   parameter int VEC_W       = 8,
   parameter int VEC_BASE    = 4,
   parameter int VEC_STEP    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int NUM_TMR     = 2,
   parameter bit INT_FALLING = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               int_n,
   input  logic               tb_tick,
   input  logic               rtc_tick,
   input  logic [NUM_TMR-1:0] tmr_ovf,
   input  logic               t2_edge,
   input  logic               stack_full,
   input  logic               ret_exec,
   input  logic               reti_exec,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   output logic               irq_push,
   output logic [VEC_W-1:0]   irq_vector
);
   localparam int VEC_TOP = VEC_BASE + (NUM_SRC - 1) * VEC_STEP;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (NUM_TMR < 1) begin : g_bad_tmr
         $error("NUM_TMR must be at least 1");
      end
      if (VEC_STEP < 1 || VEC_TOP >= (1 << VEC_W)) begin : g_bad_vec
         $error("vector range does not fit VEC_W");
      end
   endgenerate

   logic               ext_edge;
   logic               tmr_any;
   logic [NUM_SRC-1:0] hw_set;
   logic               gie_q;
   logic [NUM_SRC-1:0] en_q, flag_q;
   logic [REG_W-1:0]   img0, img1;
   logic               ack_w;
   logic [SRC_W-1:0]   ack_src;
   logic [VEC_W-1:0]   vec_n;

   irqv_sync_edge #(
      .STAGES  (SYNC_STAGES),
      .FALLING (INT_FALLING)
   ) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin        (int_n),
      .edge_pulse (ext_edge)
   );

   generate
      if (NUM_TMR == 1) begin : g_tmr_one
         assign tmr_any = tmr_ovf[0];
      end else begin : g_tmr_many
         assign tmr_any = |tmr_ovf;
      end
   endgenerate

   always_comb begin
      hw_set          = '0;
      hw_set[SRC_EXT] = ext_edge;
      hw_set[SRC_TB]  = tb_tick;
      hw_set[SRC_RTC] = rtc_tick;
      hw_set[SRC_TMR] = tmr_any;
   end

   irqv_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .wr_sel  (bus_sel),
      .wr_data (bus_wdata),
      .hw_set  (hw_set),
      .ack     (ack_w),
      .ack_src (ack_src),
      .reti    (reti_exec),
      .gie     (gie_q),
      .en      (en_q),
      .flag    (flag_q),
      .img0    (img0),
      .img1    (img1)
   );

   irqv_arb u_arb (
      .strobe     (t2_edge),
      .gie        (gie_q),
      .stack_full (stack_full),
      .en         (en_q),
      .flag       (flag_q),
      .ack        (ack_w),
      .ack_src    (ack_src)
   );

   assign vec_n     = VEC_W'(VEC_BASE + int'(ack_src) * VEC_STEP);
   assign bus_rdata = bus_sel ? img1 : img0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_push   <= 1'b0;
         irq_vector <= '0;
      end else begin
         irq_push <= ack_w;
         if (ack_w) irq_vector <= vec_n;
      end
   end
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk
   import irqv_pkg::*;
#(
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 4,
   parameter int VEC_STEP = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             t2_edge,
   input logic             stack_full,
   input logic             ret_exec,
   input logic             reti_exec,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic             irq_push,
   input logic [VEC_W-1:0] irq_vector,
   input logic             gie,
   input logic             ack
);
   localparam logic [VEC_W-1:0] V0 = VEC_W'(VEC_BASE);
   localparam logic [VEC_W-1:0] V1 = VEC_W'(VEC_BASE + VEC_STEP);
   localparam logic [VEC_W-1:0] V2 = VEC_W'(VEC_BASE + 2 * VEC_STEP);
   localparam logic [VEC_W-1:0] V3 = VEC_W'(VEC_BASE + 3 * VEC_STEP);

   p_vec_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_push |-> (irq_vector == V0 || irq_vector == V1 ||
                    irq_vector == V2 || irq_vector == V3));

   p_ack_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (t2_edge && gie));

   p_push_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_push |-> $past(ack));

   p_stack_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stack_full |-> !ack);

   p_gie_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_push |-> !gie);

   p_single_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_push |=> !irq_push);

   p_reti_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_exec && !ack) |=> gie);

   p_ret_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_exec && !reti_exec && !ack && !(bus_wr && !bus_sel))
         |=> (gie == $past(gie)));
endmodule

bind irq_vector_ctrl irqv_chk #(
   .VEC_W    (VEC_W),
   .VEC_BASE (VEC_BASE),
   .VEC_STEP (VEC_STEP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .t2_edge    (t2_edge),
   .stack_full (stack_full),
   .ret_exec   (ret_exec),
   .reti_exec  (reti_exec),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .irq_push   (irq_push),
   .irq_vector (irq_vector),
   .gie        (gie_q),
   .ack        (ack_w)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       int_n = 1'b1;
   logic       tb_tick = 1'b0, rtc_tick = 1'b0;
   logic [1:0] tmr_ovf = 2'b00;
   logic       t2_edge = 1'b0, stack_full = 1'b0;
   logic       ret_exec = 1'b0, reti_exec = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_push;
   logic [7:0] irq_vector;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_vector_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .int_n(int_n), .tb_tick(tb_tick),
      .rtc_tick(rtc_tick), .tmr_ovf(tmr_ovf), .t2_edge(t2_edge),
      .stack_full(stack_full), .ret_exec(ret_exec), .reti_exec(reti_exec),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_push(irq_push), .irq_vector(irq_vector)
   );

   // {wr0, wr1, stack_full nibble, push nibble, vector, read0, read1}
   localparam int NROW = 12;
   localparam logic [47:0] TBL [0:NROW-1] = '{
      48'h11_00_0_0_00_11_00,  // R5 flag without enable
      48'h13_00_0_1_04_02_00,  // R5 R6 external
      48'h25_00_0_1_08_04_00,  // R5 R6 time base
      48'h49_00_0_1_0C_08_00,  // R5 R6 rtc
      48'h01_11_0_1_10_00_01,  // R2 R5 timer
      48'h7F_11_0_1_04_6E_11,  // R7 all pending
      48'h6D_00_0_1_08_4C_00,  // R7 tb over rtc
      48'h49_11_0_1_0C_08_11,  // R7 rtc over timer
      48'h13_00_1_0_00_13_00,  // R8 stack full
      48'h12_00_0_0_00_12_00,  // R5 global off
      48'h00_FF_0_0_00_00_11,  // R2 unused bits
      48'hFF_00_0_1_04_6E_00   // R1 bit7 reads 0
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [7:0] d);
      bus_sel = sel;
      #0.5;
      d = bus_rdata;
   endtask

   // drive the strobe for one cycle; returns at the negedge where push is visible
   task automatic strobe;
      @(negedge clk);
      t2_edge = 1'b1;
      @(negedge clk);
      t2_edge = 1'b0;
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   initial begin : watchdog
      #200000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] r;
      repeat (3) @(negedge clk);
      // R12 reset state
      rd(1'b0, r); check("R12 reg0", r, 8'h00);
      rd(1'b1, r); check("R12 reg1", r, 8'h00);
      check("R12 push", irq_push, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NROW; i++) begin
         logic [47:0] v;
         v = TBL[i];
         wr(1'b1, v[39:32]);
         wr(1'b0, v[47:40]);
         stack_full = v[28];
         strobe();
         check($sformatf("R5 row%0d push", i), irq_push, v[24]);
         if (v[24]) check($sformatf("R7 row%0d vector", i), irq_vector, v[23:16]);
         stack_full = 1'b0;
         rd(1'b0, r); check($sformatf("R6 row%0d reg0", i), r, v[15:8]);
         rd(1'b1, r); check($sformatf("R6 row%0d reg1", i), r, v[7:0]);
      end

      // R1 write/readback of enables only
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h8E);
      rd(1'b0, r); check("R1 readback", r, 8'h0E);

      // R3 falling edge latency through synchronizer
      wr(1'b0, 8'h02);
      @(negedge clk); int_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rd(1'b0, r); check("R3 not yet", r[4], 1'b0);
      @(negedge clk);
      rd(1'b0, r); check("R3 flag set", r[4], 1'b1);
      wr(1'b0, 8'h02);
      @(negedge clk); int_n = 1'b1;
      repeat (5) @(negedge clk);
      rd(1'b0, r); check("R3 rising ignored", r[4], 1'b0);

      // R4 tick sources
      wr(1'b0, 8'h00); wr(1'b1, 8'h00);
      pulse(tb_tick);
      rd(1'b0, r); check("R4 tb flag", r, 8'h20);
      pulse(rtc_tick);
      rd(1'b0, r); check("R4 rtc flag", r, 8'h60);
      @(negedge clk); tmr_ovf = 2'b10; @(negedge clk); tmr_ovf = 2'b00;
      rd(1'b1, r); check("R4 timer B", r, 8'h10);
      wr(1'b1, 8'h00);
      @(negedge clk); tmr_ovf = 2'b01; @(negedge clk); tmr_ovf = 2'b00;
      rd(1'b1, r); check("R4 timer A", r, 8'h10);

      // R11 hardware set beats software clear
      wr(1'b1, 8'h00);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = 8'h00; tb_tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; tb_tick = 1'b0;
      rd(1'b0, r); check("R11 set wins", r, 8'h20);

      // R9 ret vs reti
      wr(1'b0, 8'h00);
      pulse(ret_exec);
      rd(1'b0, r); check("R9 ret keeps 0", r[0], 1'b0);
      pulse(reti_exec);
      rd(1'b0, r); check("R9 reti sets", r[0], 1'b1);
      pulse(ret_exec);
      rd(1'b0, r); check("R9 ret keeps 1", r[0], 1'b1);

      // R8 pending through stack full, taken later
      wr(1'b0, 8'h13);
      stack_full = 1'b1;
      strobe();
      check("R8 blocked", irq_push, 1'b0);
      stack_full = 1'b0;
      strobe();
      check("R8 released push", irq_push, 1'b1);
      check("R8 released vector", irq_vector, 8'h04);
      @(negedge clk);
      check("R5 push one cycle", irq_push, 1'b0);

      // R10 record while global off, service after reti
      wr(1'b0, 8'h04);
      pulse(tb_tick);
      strobe();
      check("R10 no push when off", irq_push, 1'b0);
      rd(1'b0, r); check("R10 flag recorded", r, 8'h24);
      pulse(reti_exec);
      strobe();
      check("R10 push after reti", irq_push, 1'b1);
      check("R10 vector", irq_vector, 8'h08);
      rd(1'b0, r); check("R6 gie and flag cleared", r, 8'h04);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule